// File: doc/BRIEF.md
# First/Next Error Logging and Signaling Unit

This unit watches a vector of single-cycle error event lines and keeps a record of them in two write-one-to-clear status registers. The first register holds whatever arrives while it is empty. The second register collects everything that arrives after that. Software can clear either register bit by bit through a small register port, so the order of failures can be reconstructed after the fact.

Each source bit has a fixed class, set by parameter. Some sources drive a bus-init pulse, some drive a bus-error pulse, and the rest are non-fatal and drive a level interrupt. A per-source mask blocks only the signaling; the error is still logged. Each bus pulse has an arming bit that hardware drops at the moment the pulse goes out. When software sets the bit again while an unmasked error of that class is still logged, the pulse repeats. When a correctable and an uncorrectable memory error arrive together, only the uncorrectable one is kept. Its transaction ID is captured and held.

Register map on `reg_addr`: 0 = first-error status (W1C), 1 = next-error status (W1C), 2 = mask (read/write), 3 = arming (bit 0 bus-init, bit 1 bus-error; read/write), 4 = captured transaction ID (read only). Other addresses read as zero.

Top module: `err_log_unit`

## Requirements
- R1: After reset, both status registers, the mask, the arming bits and the captured ID read 0, and `bus_init`, `bus_err` and `irq` are low.
- R2: An error event seen at a clock edge while the first-error register is zero sets its bit in the first-error register. All events arriving at that same edge go there.
- R3: An error event seen at an edge while the first-error register is non-zero sets its bit in the next-error register only.
- R4: Writing address 0 or 1 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A masked source still sets its status bit and still fills the first-error register, which sends later errors to the next-error register.
- R6: A masked source raises neither `irq` nor a bus pulse, and it leaves the arming bits unchanged.
- R7: With bus-init armed, a logged unmasked bus-init-class error (default bit 7) makes `bus_init` high for exactly one cycle, starting at the edge after the logging edge. The bus-init arming bit reads 0 from that same edge on.
- R8: Setting an arming bit, or unmasking a source, while an unmasked error of that class is logged in either register gives one more pulse on the next edge.
- R9: `bus_err` follows R7 for bus-error-class sources (default bit 6) under arming bit 1, independently of `bus_init`.
- R10: A bus-class error that lands in the next-error register still produces its pulse.
- R11: `irq` is high whenever any unmasked non-fatal bit (default bits 0 to 5) is set in either register. It falls once all such bits are cleared.
- R12: When the correctable source (bit 0) and the uncorrectable source (bit 7) fire at the same edge, only bit 7 is logged.
- R13: `err_tid` is captured when bit 7 is logged while bit 7 is clear in both registers. The captured value is held until bit 7 is clear in both registers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | N_SRC | Error event pulses, one per source |
| err_tid | input | TID_W | Transaction ID accompanying an uncorrectable event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data (combinational on address) |
| bus_init | output | 1 | One-cycle bus-init pulse |
| bus_err | output | 1 | One-cycle bus-error pulse |
| irq | output | 1 | Level interrupt request for non-fatal errors |

## Verification
Two functions can coincide in one cycle. The correctable and uncorrectable events can arrive together, which collides with first-versus-next routing. An arming pulse can also meet an already pending error. The vector table drives the combined correctable-plus-uncorrectable pattern both into an empty first-error register and behind a logged error, and expects only bit 7 in whichever register received it. Separately, the arming bit is rewritten while an error is still logged, or a mask is lifted while one is still logged, and the bench expects exactly one pulse one edge later, with the arming bit dropping in that same cycle.

// File: rtl/err_log_unit.sv
module err_log_unit #(
  parameter int N_SRC = 8,
  parameter int TID_W = 8,
  parameter logic [N_SRC-1:0] INIT_SRC = 8'h80,
  parameter logic [N_SRC-1:0] BERR_SRC = 8'h40,
  parameter int SBE_IDX = 0,
  parameter int DBE_IDX = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] err_evt,
  input  logic [TID_W-1:0] err_tid,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             bus_init,
  output logic             bus_err,
  output logic             irq
);
  localparam logic [N_SRC-1:0] NONFATAL = ~(INIT_SRC | BERR_SRC);
  localparam logic [2:0] A_FIRST = 3'd0, A_NEXT = 3'd1, A_MASK = 3'd2, A_ARM = 3'd3, A_TID = 3'd4;

  logic [N_SRC-1:0] first_q, next_q, mask_q;
  logic [TID_W-1:0] tid_q;
  logic             init_en_q, berr_en_q;

  wire [N_SRC-1:0] sbe_kill  = err_evt[DBE_IDX] ? (N_SRC'(1) << SBE_IDX) : '0;
  wire [N_SRC-1:0] evt_eff   = err_evt & ~sbe_kill;
  wire             first_emp = ~|first_q;
  wire [N_SRC-1:0] clr_first = (reg_wr && reg_addr == A_FIRST) ? reg_wdata : '0;
  wire [N_SRC-1:0] clr_next  = (reg_wr && reg_addr == A_NEXT)  ? reg_wdata : '0;
  wire             wr_mask   = reg_wr && reg_addr == A_MASK;
  wire             wr_arm    = reg_wr && reg_addr == A_ARM;
  wire [N_SRC-1:0] pend      = (first_q | next_q) & ~mask_q;
  wire             dbe_held  = first_q[DBE_IDX] | next_q[DBE_IDX];
  wire             fire_init = init_en_q && |(pend & INIT_SRC);
  wire             fire_berr = berr_en_q && |(pend & BERR_SRC);

  assign irq = |(pend & NONFATAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q   <= '0;
      next_q    <= '0;
      mask_q    <= '0;
      tid_q     <= '0;
      init_en_q <= 1'b0;
      berr_en_q <= 1'b0;
      bus_init  <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      first_q <= (first_q & ~clr_first) | (first_emp ? evt_eff : '0);
      next_q  <= (next_q & ~clr_next) | (first_emp ? '0 : evt_eff);
      if (wr_mask) mask_q <= reg_wdata;
      if (evt_eff[DBE_IDX] && !dbe_held) tid_q <= err_tid;
      init_en_q <= fire_init ? 1'b0 : (wr_arm ? reg_wdata[0] : init_en_q);
      berr_en_q <= fire_berr ? 1'b0 : (wr_arm ? reg_wdata[1] : berr_en_q);
      bus_init  <= fire_init;
      bus_err   <= fire_berr;
    end
  end

  always_comb begin
    case (reg_addr)
      A_FIRST: reg_rdata = first_q;
      A_NEXT:  reg_rdata = next_q;
      A_MASK:  reg_rdata = mask_q;
      A_ARM:   reg_rdata = N_SRC'({berr_en_q, init_en_q});
      A_TID:   reg_rdata = N_SRC'(tid_q);
      default: reg_rdata = '0;
    endcase
  end

  a_r2_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q == '0 && err_evt != '0) |=> (first_q != '0));

  a_r3_next_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|(next_q & ~$past(next_q))) |-> $past(|first_q));

  a_r12_dbe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q == '0 && err_evt[SBE_IDX] && err_evt[DBE_IDX]) |=> (first_q[DBE_IDX] && !first_q[SBE_IDX]));

  a_r7_init_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |-> !init_en_q);

  a_r7_init_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> !bus_init);

  a_r9_berr_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!berr_en_q ##1 !bus_err));
endmodule

// File: tb/sim_err_log_unit.sv
`timescale 1ns/1ps
module sim_err_log_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] err_evt = '0, err_tid = '0, reg_wdata = '0, reg_rdata;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       bus_init, bus_err, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  err_log_unit u0 (.clk, .rst_n, .err_evt, .err_tid, .reg_wr, .reg_addr,
                   .reg_wdata, .reg_rdata, .bus_init, .bus_err, .irq);

  // {event A, event B on the following edge, expected first, expected next}
  localparam logic [31:0] VEC [8] = '{
    32'h01_00_01_00, 32'h06_00_06_00, 32'h02_04_02_04, 32'h10_10_10_10,
    32'h01_81_01_80, 32'h81_00_80_00, 32'h20_0C_20_0C, 32'h00_40_40_00};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse(logic [7:0] e, logic [7:0] t);
    @(negedge clk); err_evt = e; err_tid = t;
    @(negedge clk); err_evt = '0;
  endtask

  task automatic clear_all;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); check("R1 reg", d, 0); end
    check("R1 outputs", {bus_init, bus_err, irq}, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk); err_evt = VEC[i][31:24];
      @(negedge clk); err_evt = VEC[i][23:16];
      @(negedge clk); err_evt = '0;
      rd(3'd0, d); check($sformatf("R2/R12 first vec%0d", i), d, VEC[i][15:8]);
      rd(3'd1, d); check($sformatf("R3/R12 next vec%0d", i), d, VEC[i][7:0]);
      clear_all;
    end

    pulse(8'h03, 0);
    wr(3'd0, 8'h00); rd(3'd0, d); check("R4 zero write keeps", d, 8'h03);
    wr(3'd0, 8'h01); rd(3'd0, d); check("R4 one write clears", d, 8'h02);
    clear_all;

    wr(3'd2, 8'h02);
    pulse(8'h02, 0); rd(3'd0, d); check("R5 masked logged", d, 8'h02);
    check("R6 masked no irq", irq, 0);
    pulse(8'h04, 0); rd(3'd1, d); check("R5 later goes next", d, 8'h04);
    check("R11 irq from next", irq, 1);
    wr(3'd1, 8'h04); check("R11 irq falls", irq, 0);
    clear_all; wr(3'd2, 8'h00);

    wr(3'd3, 8'h01);
    pulse(8'h80, 8'h5A);
    check("R7 no pulse yet", bus_init, 0);
    @(negedge clk); check("R7 pulse", bus_init, 1);
    rd(3'd3, d); check("R7 arm cleared", d, 0);
    @(negedge clk); check("R7 one cycle", bus_init, 0);
    check("R11 fatal no irq", irq, 0);
    rd(3'd4, d); check("R13 tid captured", d, 8'h5A);
    pulse(8'h80, 8'h33);
    rd(3'd1, d); check("R3 dbe to next", d, 8'h80);
    rd(3'd4, d); check("R13 tid held", d, 8'h5A);
    @(negedge clk); check("R7 disarmed silent", bus_init, 0);
    wr(3'd3, 8'h01); check("R8 before rearm pulse", bus_init, 0);
    @(negedge clk); check("R8 rearm pulse", bus_init, 1);
    @(negedge clk); check("R8 rearm one cycle", bus_init, 0);
    wr(3'd0, 8'h80); rd(3'd4, d); check("R13 held via next", d, 8'h5A);
    wr(3'd1, 8'h80);
    pulse(8'h80, 8'h77); rd(3'd4, d); check("R13 recapture", d, 8'h77);
    clear_all;

    wr(3'd3, 8'h01);
    pulse(8'h01, 0); check("R11 irq from first", irq, 1);
    pulse(8'h80, 0);
    @(negedge clk); check("R10 next fatal pulse", bus_init, 1);
    wr(3'd0, 8'hFF); check("R11 irq cleared", irq, 0);
    wr(3'd1, 8'hFF);

    wr(3'd3, 8'h02);
    pulse(8'h40, 0);
    @(negedge clk); check("R9 berr pulse", {bus_err, bus_init}, 2'b10);
    rd(3'd3, d); check("R9 berr arm cleared", d, 0);
    clear_all;

    wr(3'd2, 8'h40); wr(3'd3, 8'h02);
    pulse(8'h40, 0);
    seen = 1'b0;
    repeat (4) begin @(negedge clk); seen |= bus_err; end
    check("R6 masked no berr", seen, 0);
    rd(3'd3, d); check("R6 arm kept", d, 8'h02);
    wr(3'd2, 8'h00); check("R8 unmask wait", bus_err, 0);
    @(negedge clk); check("R8 unmask pulse", bus_err, 1);
    clear_all;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule